// File: doc/BRIEF.md
# Beat-Aligned Reset Synchronizer

This block turns a debounced reset request into a reset that starts and ends only on the upbeat phase of a two-phase beat clock. Playback logic alternates downbeat and upbeat enables. Because the reset can change only on an upbeat, the first enable that downstream logic sees after release is always a downbeat, so a performance restarts cleanly from its first beat.

The request first passes through a chain of synchronizing flops. The synchronized value is then captured into a single reset flop, and only on cycles where the upbeat enable is high. The block runs on the free-running clock and takes its upbeat enable from the ungated phase generator. It therefore still answers a request after the sequencer has finished and gated off its own beat enables. An asynchronous power-on reset puts the output into the asserted state. The output stays asserted until the first upbeat at which no synchronized request is present.

Top module: `beat_reset_sync`

## Requirements
- R1: While `por_n` is low, and after it rises until the first upbeat edge where the synchronized request is low, `rst_o` is 1 and `rst_no` is 0.
- R2: `rst_no` is always the logical inverse of `rst_o`.
- R3: `rst_o` changes value only at a clock edge where `upbeat_en` is high.
- R4: `reset_req` passes through `SYNC_STAGES` flops (default 2). At an edge where `upbeat_en` is high, `rst_o` takes the value that `reset_req` had `SYNC_STAGES` edges earlier. The synchronizer flops power up as 1.
- R5: A request held longer than the spacing between upbeats is always caught. `rst_o` rises at the first upbeat after the request reaches the end of the synchronizer, and stays 1 for as long as the request stays high.
- R6: A request that is low again by the time its synchronized value would be sampled at an upbeat has no effect: `rst_o` stays 0.
- R7: Once the request falls, `rst_o` clears at the first upbeat edge after the low value reaches the end of the synchronizer. This holds even when upbeats are irregular or widely spaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running (ungated) clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| upbeat_en | input | 1 | One-cycle enable marking the upbeat phase, taken from the ungated phase generator |
| reset_req | input | 1 | Debounced reset request, asynchronous to the beats |
| rst_o | output | 1 | Beat-aligned reset, active high |
| rst_no | output | 1 | Beat-aligned reset, active low |

## Verification
The assertions check on every cycle that the reset moves only on an upbeat edge. They also check that each rise or fall of the reset matches the synchronizer output sampled at that upbeat. The latency through the synchronizer, the power-up hold, the ignored short glitch and the inverse output can only be shown by the bench. It runs directed request patterns against a behavioural reference model, with both regular and irregular upbeat spacing.

// File: rtl/beat_reset_sync_pkg.sv
package beat_reset_sync_pkg;

    localparam int unsigned DEFAULT_SYNC_STAGES = 2;

    typedef enum logic {
        RST_RELEASED = 1'b0,
        RST_HELD     = 1'b1
    } rst_state_e;

endpackage

// File: rtl/beat_reset_sync_chain.sv
module beat_reset_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] shreg;
    } chain_t;

    chain_t chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                chain_d = chain_q;
                chain_d.shreg[0] = din;
            end
        end else begin : g_multi
            always_comb begin
                chain_d = chain_q;
                chain_d.shreg = {chain_q.shreg[STAGES-2:0], din};
            end
        end
    endgenerate

    // power up as "request present" so the reset is held conservatively
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain_q.shreg <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q.shreg[LAST];

endmodule

// File: rtl/beat_reset_sync_hold.sv
module beat_reset_sync_hold
    import beat_reset_sync_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sample_en,
    input  logic req_sync,
    output logic held
);

    typedef struct packed {
        rst_state_e st;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (sample_en) begin
            hold_d.st = req_sync ? RST_HELD : RST_RELEASED;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_q.st <= RST_HELD;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign held = (hold_q.st == RST_HELD);

endmodule

// File: rtl/beat_reset_sync.sv
module beat_reset_sync
    import beat_reset_sync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic por_n,
    input  logic upbeat_en,
    input  logic reset_req,
    output logic rst_o,
    output logic rst_no
);

    logic req_sync;
    logic held;

    beat_reset_sync_chain #(
        .STAGES (SYNC_STAGES)
    ) u_chain (
        .clk   (clk),
        .por_n (por_n),
        .din   (reset_req),
        .dout  (req_sync)
    );

    beat_reset_sync_hold u_hold (
        .clk       (clk),
        .por_n     (por_n),
        .sample_en (upbeat_en),
        .req_sync  (req_sync),
        .held      (held)
    );

    assign rst_o  = held;
    assign rst_no = ~held;

endmodule

// File: rtl/beat_reset_sync_chk.sv
module beat_reset_sync_chk (
    input logic clk,
    input logic por_n,
    input logic upbeat_en,
    input logic req_sync,
    input logic rst_o
);

    // R3
    only_upbeat_change_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(upbeat_en) |-> $stable(rst_o));

    // R7
    release_needs_low_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_o) |-> ($past(upbeat_en) && !$past(req_sync)));

    // R5
    assert_needs_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_o) |-> ($past(upbeat_en) && $past(req_sync)));

    // R4
    upbeat_sample_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(upbeat_en) |-> (rst_o == $past(req_sync)));

endmodule

bind beat_reset_sync beat_reset_sync_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .upbeat_en (upbeat_en),
    .req_sync  (req_sync),
    .rst_o     (rst_o)
);

// File: tb/beat_reset_sync_bench.sv
`timescale 1ns/1ps
module beat_reset_sync_bench;

    localparam int STAGES = 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic upbeat_en = 1'b0;
    logic reset_req = 1'b0;
    logic rst_o, rst_no;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit m_rst = 1'b1;
    bit hist[$];
    bit prev_rst = 1'b1;
    bit last_up = 1'b0;

    always #2.5 clk = ~clk;

    beat_reset_sync #(.SYNC_STAGES(STAGES)) u_beat_reset_sync (
        .clk       (clk),
        .por_n     (por_n),
        .upbeat_en (upbeat_en),
        .reset_req (reset_req),
        .rst_o     (rst_o),
        .rst_no    (rst_no)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < STAGES; i++) hist.push_back(1'b1);
        m_rst = 1'b1;
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic tick(input bit up, input bit req);
        upbeat_en = up;
        reset_req = req;
        @(posedge clk);
        if (up) m_rst = hist[STAGES-1];
        hist.push_front(req);
        void'(hist.pop_back());
        last_up = up;
        @(negedge clk);
        chk("R4 model", rst_o, m_rst);
        chk("R2 inverse", rst_no, ~rst_o);
        if (rst_o !== prev_rst) chk("R3 change on upbeat only", last_up, 1'b1);
        prev_rst = rst_o;
    endtask

    // regular beats: upbeat every fourth cycle
    task automatic beats(input int n, input bit req);
        for (int i = 0; i < n; i++) tick((i % 4) == 2, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 por rst_o", rst_o, 1'b1);
        chk("R1 por rst_no", rst_no, 1'b0);
        por_n = 1'b1;
        // no upbeat yet: still held
        tick(0, 0); tick(0, 0); tick(0, 0);
        chk("R1 held before upbeat", rst_o, 1'b1);
        tick(1, 0);
        chk("R1 released at first clean upbeat", rst_o, 1'b0);
        beats(8, 0);
        // long request
        beats(12, 1);
        chk("R5 long request caught", rst_o, 1'b1);
        beats(4, 1);
        chk("R5 held while request high", rst_o, 1'b1);
        // release
        beats(12, 0);
        chk("R7 released after request fell", rst_o, 1'b0);
        // short glitch not reaching an upbeat sample
        tick(0, 1); tick(0, 0); tick(0, 0); tick(1, 0);
        chk("R6 glitch ignored", rst_o, 1'b0);
        tick(0, 0); tick(1, 0);
        chk("R6 glitch ignored later", rst_o, 1'b0);
        // latency: request sampled exactly STAGES edges before an upbeat
        tick(0, 1); tick(0, 0); tick(1, 0);
        chk("R4 latency capture", rst_o, 1'b1);
        tick(0, 0); tick(0, 0); tick(1, 0);
        chk("R7 clear after capture", rst_o, 1'b0);
        // irregular, widely spaced upbeats (sequencer halted)
        for (int i = 0; i < 20; i++) tick(0, 1);
        chk("R3 no upbeat no change", rst_o, 1'b0);
        tick(1, 1);
        chk("R5 caught on sparse upbeat", rst_o, 1'b1);
        for (int i = 0; i < 15; i++) tick(0, 0);
        chk("R7 held until upbeat", rst_o, 1'b1);
        tick(1, 0);
        chk("R7 clear on sparse upbeat", rst_o, 1'b0);
        // power-on reset again mid-run
        por_n = 1'b0;
        model_reset();
        #1;
        chk("R1 async por", rst_o, 1'b1);
        @(negedge clk);
        por_n = 1'b1;
        prev_rst = 1'b1;
        beats(16, 0);
        chk("R1 release after second por", rst_o, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule